// File: doc/BRIEF.md
# Rule Bitset Intersection Engine

This block narrows a set of candidate rules down to the ones that accept an input. It holds one bit per rule, and the rule's integer identity is that bit's position. Each evaluation opens with every bit set, so at first all rules are candidates. The caller then presents one mask identifier for each attribute value it has pulled from the input. The engine fetches the matching rule mask from an internal mask store and clears every candidate bit that the mask does not also hold. The mask store is a single flat array of 64-bit words, filled through a plain write port.

The bitset is processed one word per clock. Once the caller flags a value as the final one, the surviving bitset is offered as the result. If the candidate set becomes empty first, the result is offered right away with the "any" flag low. The engine then quietly accepts and drops the rest of that evaluation's identifiers, up to and including the flagged one. A new evaluation cannot begin until the consumer has taken the current result.

Top module: `rule_intersect_engine`

## Requirements
- R1: After reset, `res_valid` is 0, `id_ready` is 1 and `res_rules` is all ones.
- R2: The mask for identifier N occupies mask-store word addresses N*4 to N*4+3 (for the default sizes), and word k of a mask governs rule bits 64k+63 down to 64k.
- R3: An evaluation with a single identifier flagged last yields exactly that identifier's mask as `res_rules`.
- R4: An evaluation with several identifiers yields the bitwise AND of all their masks.
- R5: When the running AND becomes all zero before the last-flagged identifier, the result is offered at once with `res_rules` all zero and `res_any` 0.
- R6: After an early-ended result is consumed, the identifiers that follow are accepted and dropped up to and including the one flagged last, no further result appears, and `id_ready` is 1 once that flagged identifier has gone.
- R7: `res_any` is 1 exactly when the offered `res_rules` has at least one bit set.
- R8: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_rules` and `res_any` hold, and `id_ready` stays 0 even when `id_valid` is driven.
- R9: In the cycle after a result is consumed, `res_rules` is all ones again, and nothing from the previous evaluation carries over.
- R10: A write to the mask store changes only the addressed word, and the next evaluation that reads that word uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_wr_en | input | 1 | Mask store write strobe |
| mem_wr_addr | input | 6 | Mask store word address |
| mem_wr_data | input | 64 | Mask store write data |
| id_valid | input | 1 | Mask identifier offered |
| id_ready | output | 1 | Engine takes an identifier this cycle |
| id_value | input | 4 | Mask identifier |
| id_last | input | 1 | Marks the final identifier of an evaluation |
| res_valid | output | 1 | Result offered, held until consumed |
| res_ready | input | 1 | Consumer takes the result |
| res_rules | output | 256 | Surviving rule bitset |
| res_any | output | 1 | At least one rule survived |

## Verification
The case that is hardest to reach from the ports is an early stop in the middle of an evaluation. Here the set empties while the caller still has identifiers queued, and those identifiers must be swallowed rather than start a new evaluation. The bench reaches it with masks built to be disjoint (alternating bit patterns), placed before further identifiers in the stimulus table. It takes the result while its send loop is still running, then checks that the leftover identifiers produce nothing and that the next table entry starts from a full bitset. A separate masks-in-one-word pattern catches any error in word addressing.

// File: rtl/rbi_pkg.sv
package rbi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_TAIL = 3'd2,
    ST_EVAL = 3'd3,
    ST_OUT  = 3'd4,
    ST_SKIP = 3'd5
  } rbi_state_t;
endpackage

// File: rtl/rbi_mask_ram.sv
module rbi_mask_ram #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // write port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port, read-first
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rbi_bitset.sv
module rbi_bitset #(
  parameter int WORD_W = 64,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    init,
  input  logic                    and_en,
  input  logic [IDX_W-1:0]        and_idx,
  input  logic [WORD_W-1:0]       and_word,
  output logic [WORDS*WORD_W-1:0] bits
);
  // one register per word, each narrowed only when its index comes up
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst || init) begin
        q <= '1;
      end else if (and_en && (and_idx == IDX_W'(g))) begin
        q <= q & and_word;
      end
    end
    assign bits[g*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/rbi_ctrl.sv
module rbi_ctrl
  import rbi_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 6,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_valid,
  input  logic [ID_W-1:0]   id_value,
  input  logic              id_last,
  output logic              id_ready,
  input  logic              res_ready,
  output logic              res_valid,
  output logic              res_any,
  input  logic              set_nonzero,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic              and_en,
  output logic [IDX_W-1:0]  and_idx,
  output logic              bs_init
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  rbi_state_t       state;
  logic [ID_W-1:0]  id_q;
  logic             last_q;
  logic             skip_q;
  logic             any_q;
  logic [IDX_W-1:0] rd_cnt;
  logic             pipe_vld;
  logic [IDX_W-1:0] pipe_idx;

  // flat mask store: word address = id * WORDS + word index
  assign ram_raddr = ADDR_W'(id_q) * ADDR_W'(WORDS) + ADDR_W'(rd_cnt);
  assign ram_re    = (state == ST_READ);

  // read data arrives one cycle after the address, tagged by pipe_idx
  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_vld <= 1'b0;
      pipe_idx <= '0;
    end else begin
      pipe_vld <= (state == ST_READ);
      pipe_idx <= rd_cnt;
    end
  end
  assign and_en  = pipe_vld;
  assign and_idx = pipe_idx;

  assign bs_init   = (state == ST_OUT) && res_ready;
  assign id_ready  = (state == ST_IDLE) || (state == ST_SKIP);
  assign res_valid = (state == ST_OUT);
  assign res_any   = any_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      id_q   <= '0;
      last_q <= 1'b0;
      skip_q <= 1'b0;
      any_q  <= 1'b1;
      rd_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (id_valid) begin
            id_q   <= id_value;
            last_q <= id_last;
            rd_cnt <= '0;
            state  <= ST_READ;
          end
        end
        ST_READ: begin
          rd_cnt <= rd_cnt + 1'b1;
          if (rd_cnt == LAST_IDX) state <= ST_TAIL;
        end
        ST_TAIL: begin
          // final word lands in the bitset at the end of this cycle
          state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (!set_nonzero) begin
            any_q  <= 1'b0;
            skip_q <= !last_q;
            state  <= ST_OUT;
          end else if (last_q) begin
            any_q  <= 1'b1;
            skip_q <= 1'b0;
            state  <= ST_OUT;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_OUT: begin
          if (res_ready) begin
            any_q <= 1'b1;
            state <= skip_q ? ST_SKIP : ST_IDLE;
          end
        end
        ST_SKIP: begin
          // drop the rest of an evaluation that ended early
          if (id_valid && id_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rule_intersect_engine.sv
module rule_intersect_engine #(
  parameter int RULE_COUNT = 256,
  parameter int WORD_W     = 64,
  parameter int MASK_COUNT = 16,
  localparam int WORDS  = RULE_COUNT / WORD_W,
  localparam int ID_W   = $clog2(MASK_COUNT),
  localparam int DEPTH  = MASK_COUNT * WORDS,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int IDX_W  = $clog2(WORDS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mem_wr_en,
  input  logic [ADDR_W-1:0]     mem_wr_addr,
  input  logic [WORD_W-1:0]     mem_wr_data,
  input  logic                  id_valid,
  output logic                  id_ready,
  input  logic [ID_W-1:0]       id_value,
  input  logic                  id_last,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [RULE_COUNT-1:0] res_rules,
  output logic                  res_any
);
  logic              ram_re;
  logic [ADDR_W-1:0] ram_raddr;
  logic [WORD_W-1:0] ram_rdata;
  logic              and_en;
  logic [IDX_W-1:0]  and_idx;
  logic              bs_init;
  logic              set_nonzero;

  rbi_mask_ram #(.DATA_W(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (mem_wr_en),
    .waddr (mem_wr_addr),
    .wdata (mem_wr_data),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  rbi_bitset #(.WORD_W(WORD_W), .WORDS(WORDS)) u_set (
    .clk      (clk),
    .rst      (rst),
    .init     (bs_init),
    .and_en   (and_en),
    .and_idx  (and_idx),
    .and_word (ram_rdata),
    .bits     (res_rules)
  );

  assign set_nonzero = |res_rules;

  rbi_ctrl #(.WORDS(WORDS), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .id_valid    (id_valid),
    .id_value    (id_value),
    .id_last     (id_last),
    .id_ready    (id_ready),
    .res_ready   (res_ready),
    .res_valid   (res_valid),
    .res_any     (res_any),
    .set_nonzero (set_nonzero),
    .ram_re      (ram_re),
    .ram_raddr   (ram_raddr),
    .and_en      (and_en),
    .and_idx     (and_idx),
    .bs_init     (bs_init)
  );
endmodule

// File: rtl/rbi_checker.sv
module rbi_checker #(
  parameter int RULE_COUNT = 256
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  id_ready,
  input logic                  res_valid,
  input logic                  res_ready,
  input logic [RULE_COUNT-1:0] res_rules,
  input logic                  res_any
);
  // R8: result held until taken
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_rules) && $stable(res_any)));

  // R8: no identifier accepted while a result is pending
  p_no_accept_r8: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !id_ready);

  // R7: flag agrees with offered bitset
  p_any_match_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_any == (|res_rules)));

  // R5: an empty result carries an all-zero bitset
  p_empty_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_any) |-> (res_rules == '0));

  // R9: fresh all-ones set after consumption
  p_fresh_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready) |=> (res_rules == '1 && !res_valid));
endmodule

bind rule_intersect_engine rbi_checker #(.RULE_COUNT(RULE_COUNT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .id_ready  (id_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_rules (res_rules),
  .res_any   (res_any)
);

// File: tb/sim_rule_intersect_engine.sv
module sim_rule_intersect_engine;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         mem_wr_en = 1'b0;
  logic [5:0]   mem_wr_addr = '0;
  logic [63:0]  mem_wr_data = '0;
  logic         id_valid = 1'b0;
  logic         id_ready;
  logic [3:0]   id_value = '0;
  logic         id_last = 1'b0;
  logic         res_valid;
  logic         res_ready = 1'b0;
  logic [255:0] res_rules;
  logic         res_any;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  rule_intersect_engine u0 (
    .clk(clk), .rst(rst), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .id_valid(id_valid), .id_ready(id_ready),
    .id_value(id_value), .id_last(id_last), .res_valid(res_valid),
    .res_ready(res_ready), .res_rules(res_rules), .res_any(res_any)
  );

  logic [63:0] model [64];

  // {count[1:0], id0, id1, id2}
  localparam logic [13:0] VECS [10] = '{
    {2'd1, 4'd1,  4'd0,  4'd0},
    {2'd1, 4'd3,  4'd0,  4'd0},
    {2'd2, 4'd1,  4'd3,  4'd0},
    {2'd2, 4'd1,  4'd2,  4'd0},
    {2'd3, 4'd1,  4'd2,  4'd5},
    {2'd3, 4'd0,  4'd4,  4'd9},
    {2'd3, 4'd4,  4'd4,  4'd4},
    {2'd2, 4'd2,  4'd0,  4'd0},
    {2'd3, 4'd3,  4'd2,  4'd1},
    {2'd3, 4'd15, 4'd14, 4'd13}
  };

  function automatic logic [63:0] gen_word(input int id, input int k);
    case (id)
      0: return '1;
      1: return 64'h5555_5555_5555_5555;
      2: return 64'hAAAA_AAAA_AAAA_AAAA;
      3: return (k == 0) ? '1 : '0;
      4: return (k == 3) ? 64'h8000_0000_0000_0001 : 64'hFFFF_0000_FFFF_0000;
      default: return 64'h9E37_79B9_7F4A_7C15 * 64'(id * 4 + k + 1);
    endcase
  endfunction

  function automatic logic [255:0] mask_full(input logic [3:0] id);
    logic [255:0] m;
    for (int k = 0; k < 4; k++) m[k*64 +: 64] = model[int'(id) * 4 + k];
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(input int addr, input logic [63:0] data);
    @(negedge clk);
    mem_wr_en = 1'b1; mem_wr_addr = 6'(addr); mem_wr_data = data;
    @(negedge clk);
    mem_wr_en = 1'b0;
    model[addr] = data;
  endtask

  task automatic send_id(input logic [3:0] id, input bit last);
    int t;
    @(negedge clk);
    id_valid = 1'b1; id_value = id; id_last = last;
    t = 0;
    while (!id_ready && t < 300) begin @(negedge clk); t++; end
    if (t >= 300) check(0, "handshake", 0, 1);
    @(posedge clk);
    @(negedge clk);
    id_valid = 1'b0; id_last = 1'b0;
  endtask

  task automatic wait_ready_or_result();
    int t = 0;
    while (!id_ready && !res_valid && t < 300) begin @(negedge clk); t++; end
  endtask

  task automatic take_result(input logic [255:0] exp, input string req);
    check(res_rules == exp, req, res_rules, exp);
    check(res_any == (|exp), "R7", 256'(res_any), 256'(|exp));
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    check(!res_valid && res_rules == '1, "R9", res_rules, '1);
  endtask

  task automatic run_eval(input int n, input logic [3:0] a, input logic [3:0] b,
                          input logic [3:0] c, input string req);
    logic [3:0]   ids [3];
    logic [255:0] exp;
    bit           early;
    bit           got;
    int           t;
    ids[0] = a; ids[1] = b; ids[2] = c;
    exp = '1; early = 0; got = 0;
    for (int i = 0; i < n; i++) begin
      if (!early) begin
        exp = exp & mask_full(ids[i]);
        if (exp == '0) early = 1;
      end
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wait_ready_or_result();
      if (res_valid) begin
        take_result(exp, req);
        got = 1;
      end
      send_id(ids[i], i == n - 1);
    end
    if (!got) begin
      t = 0;
      while (!res_valid && t < 300) begin @(negedge clk); t++; end
      if (!res_valid) check(0, req, 0, 1);
      else take_result(exp, req);
    end else begin
      // R6: dropped identifiers must not produce a result
      repeat (10) @(negedge clk);
      check(!res_valid && id_ready, "R6", {res_valid, id_ready}, 2'b01);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [255:0] held;
    logic [255:0] e;
    for (int i = 0; i < 64; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(res_valid == 1'b0, "R1", 256'(res_valid), 0);
    check(id_ready == 1'b1, "R1", 256'(id_ready), 1);
    check(res_rules == '1, "R1", res_rules, '1);

    // load the flat mask store (R2 layout: id*4 + word)
    for (int id = 0; id < 16; id++)
      for (int k = 0; k < 4; k++) write_word(id * 4 + k, gen_word(id, k));

    // table walk: R2/R3 singles, R4 multi, R5/R6 early ends
    for (int v = 0; v < 10; v++) begin
      run_eval(int'(VECS[v][13:12]), VECS[v][11:8], VECS[v][7:4], VECS[v][3:0],
               (VECS[v][13:12] == 2'd1) ? "R3" : "R4");
    end

    // R2: word-selective mask lands in rule bits 63..0 only
    run_eval(1, 4'd3, 4'd0, 4'd0, "R2");

    // R5: disjoint pair mid-stream with trailing identifiers
    run_eval(3, 4'd2, 4'd1, 4'd7, "R5");

    // R8: hold result with consumer stalled and identifier offered
    send_id(4'd4, 1'b1);
    begin
      int t = 0;
      while (!res_valid && t < 300) begin @(negedge clk); t++; end
    end
    held = res_rules;
    id_valid = 1'b1; id_value = 4'd0; id_last = 1'b1;
    repeat (5) begin
      @(negedge clk);
      check(res_valid && !id_ready && res_rules == held, "R8", res_rules, held);
    end
    id_valid = 1'b0; id_last = 1'b0;
    take_result(mask_full(4'd4), "R8");

    // R10: rewrite a single word, others unchanged
    write_word(6 * 4 + 2, 64'h0123_4567_89AB_CDEF);
    e = mask_full(4'd6);
    check(e[191:128] == 64'h0123_4567_89AB_CDEF, "R10", e, e);
    run_eval(1, 4'd6, 4'd0, 4'd0, "R10");

    // R9: result after an earlier evaluation starts from all ones
    run_eval(1, 4'd0, 4'd0, 4'd0, "R9");

    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule